// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block takes a single-byte read or write request for a serial EEPROM and breaks it into the ordered list of byte-level bus operations that a two-wire (I2C) bit engine carries out. Each request carries its own addressing mode. In standard mode, address bits 10 to 8 go into the device select field of the control byte, and a single address byte follows. In extended mode, the select field holds the chip-select value from the request, and two address bytes follow, high byte first. One controller can therefore reach small and large memories without being reconfigured.

On the upstream side the request is a single-cycle pulse that is accepted while the block is idle. The block reports completion with a one-cycle `done` pulse. On that pulse the read data, the error flag and the error code are valid, and they stay valid until the next request is accepted. On the downstream side the block presents one command at a time to a bit-level engine. The command is held until the engine pulses `cmd_done`. For a sent byte, the engine returns the slave's acknowledge. For a received byte, it returns the data. The bit timing on SCL and SDA belongs to the engine, not to this block.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: Every transaction starts with a start command (cmd_op 0) and ends with a stop command (cmd_op 1). `done` goes high for exactly one cycle, in the cycle after the stop's `cmd_done`.
- R2: The first byte sent after start is a control byte laid out as {4'b1010, select[2:0], rw}. For the first control byte, rw is always 0.
- R3: In standard mode (req_ext=0) the select field equals req_addr[10:8], and exactly one address byte, req_addr[7:0], follows the control byte.
- R4: In extended mode (req_ext=1) the select field equals req_sel. Two address bytes follow: req_addr[15:8] first, then req_addr[7:0].
- R5: The mode is taken from each request. Back-to-back requests in different modes each produce their own correct sequence.
- R6: A write (req_rd=0) sends req_wdata (cmd_op 2) right after the address bytes, and then sends a stop.
- R7: After the address, a read (req_rd=1) sends a repeated start (cmd_op 0), then a control byte with rw=1, then one receive (cmd_op 3) with cmd_nack=1, then a stop. `rd_data` shows the received byte on the `done` pulse.
- R8: If a sent byte is not acknowledged (rx_ack=0), no further byte is sent. The next command is a stop, and at `done` the block reports err=1 with err_code set to 1 (first control byte), 2 (high address), 3 (low address), 4 (write data) or 5 (read control byte). A transaction that completes cleanly reports err=0 and err_code=0.
- R9: After reset the block is idle: busy=0, cmd_valid=0, done=0, err=0.
- R10: A req_valid that arrives while busy=1 is ignored. The command sequence already in progress continues unchanged.
- R11: While cmd_valid=1 and cmd_done=0, the command stays valid, and cmd_op and cmd_data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pulse, accepted when idle |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_ext | input | 1 | 1 = extended (two address bytes), 0 = standard |
| req_sel | input | 3 | Chip select value used in extended mode |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Data byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte read from the memory |
| err | output | 1 | Last transaction was aborted on a missing acknowledge |
| err_code | output | 3 | Phase that failed (0 = none) |
| cmd_valid | output | 1 | A command is presented to the bit engine |
| cmd_op | output | 2 | 0 start, 1 stop, 2 send byte, 3 receive byte |
| cmd_data | output | 8 | Byte to send |
| cmd_nack | output | 1 | On a receive, answer with NACK |
| cmd_done | input | 1 | Engine finished the current command (one-cycle pulse) |
| rx_ack | input | 1 | Slave acknowledged the sent byte, valid with cmd_done |
| rx_data | input | 8 | Received byte, valid with cmd_done |

## Verification
The assertions assume that the bit engine pulses `cmd_done` for a single cycle, only while `cmd_valid` is high, and never two cycles in a row. They also assume that `rx_ack` and `rx_data` are valid in the cycle of that pulse. The bench's bus model acknowledges each command one cycle after it first sees the command, and it drops its pulse on the following cycle, so it stays within those assumptions. The model refuses a chosen sent byte to reach each abort phase. The bench changes the request inputs only on falling clock edges, and it raises a stray request only while a transaction is in flight.

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq #(
  parameter int          AW       = 16,
  parameter logic [3:0]  DEV_CODE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_rd,
  input  logic          req_ext,
  input  logic [2:0]    req_sel,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    rd_data,
  output logic          err,
  output logic [2:0]    err_code,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [7:0]    cmd_data,
  output logic          cmd_nack,
  input  logic          cmd_done,
  input  logic          rx_ack,
  input  logic [7:0]    rx_data
);

  typedef enum logic [3:0] {
    IDLE, START, CTLW, AHI, ALO, WDAT, RSTA, CTLR, RDAT, STOP
  } st_t;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_STOP  = 2'd1;
  localparam logic [1:0] OP_SEND  = 2'd2;
  localparam logic [1:0] OP_RECV  = 2'd3;

  st_t           st;
  logic          q_rd, q_ext;
  logic [2:0]    q_sel;
  logic [AW-1:0] q_addr;
  logic [7:0]    q_wdata;
  logic [7:0]    hi_byte;
  logic [2:0]    sel_bits;
  logic          step;

  assign busy      = (st != IDLE);
  assign cmd_valid = busy;
  assign cmd_nack  = (st == RDAT);
  assign step      = cmd_valid && cmd_done;
  assign sel_bits  = q_ext ? q_sel : q_addr[10:8];
  assign hi_byte   = 8'(q_addr >> 8);

  always_comb begin
    cmd_op   = OP_SEND;
    cmd_data = 8'h00;
    case (st)
      START, RSTA: cmd_op = OP_START;
      STOP:        cmd_op = OP_STOP;
      RDAT:        cmd_op = OP_RECV;
      CTLW:        cmd_data = {DEV_CODE, sel_bits, 1'b0};
      CTLR:        cmd_data = {DEV_CODE, sel_bits, 1'b1};
      AHI:         cmd_data = hi_byte;
      ALO:         cmd_data = q_addr[7:0];
      WDAT:        cmd_data = q_wdata;
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      q_rd     <= 1'b0;
      q_ext    <= 1'b0;
      q_sel    <= '0;
      q_addr   <= '0;
      q_wdata  <= '0;
      done     <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
      err_code <= '0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        if (req_valid) begin
          q_rd     <= req_rd;
          q_ext    <= req_ext;
          q_sel    <= req_sel;
          q_addr   <= req_addr;
          q_wdata  <= req_wdata;
          err      <= 1'b0;
          err_code <= '0;
          st       <= START;
        end
      end else if (step) begin
        case (st)
          START: st <= CTLW;
          CTLW:
            if (rx_ack) st <= q_ext ? AHI : ALO;
            else begin st <= STOP; err <= 1'b1; err_code <= 3'd1; end
          AHI:
            if (rx_ack) st <= ALO;
            else begin st <= STOP; err <= 1'b1; err_code <= 3'd2; end
          ALO:
            if (rx_ack) st <= q_rd ? RSTA : WDAT;
            else begin st <= STOP; err <= 1'b1; err_code <= 3'd3; end
          WDAT: begin
            st <= STOP;
            if (!rx_ack) begin err <= 1'b1; err_code <= 3'd4; end
          end
          RSTA: st <= CTLR;
          CTLR:
            if (rx_ack) st <= RDAT;
            else begin st <= STOP; err <= 1'b1; err_code <= 3'd5; end
          RDAT: begin
            rd_data <= rx_data;
            st      <= STOP;
          end
          STOP: begin
            st   <= IDLE;
            done <= 1'b1;
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/eeprom_cmd_seq_chk.sv
module eeprom_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic [2:0] err_code,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       cmd_nack,
  input logic       cmd_done
);

  a_r11_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_data));

  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmd_valid && cmd_done && cmd_op == 2'd1));

  a_r1_start_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_valid && cmd_op == 2'd0);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  a_r7_recv_nack: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd3 |-> cmd_nack);

  a_r8_code_matches: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (err == (err_code != 3'd0)));

endmodule

bind eeprom_cmd_seq eeprom_cmd_seq_chk u_chk (.*);

// File: tb/eeprom_cmd_seq_tb.sv
module eeprom_cmd_seq_tb;
  localparam int CLK_P = 10;
  localparam int NV = 10;
  // {rd, ext, sel[2:0], addr[15:0], wdata[7:0], nack_at[2:0]}
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 16'h035A, 8'h11, 3'd0},
    {1'b1, 1'b1, 3'd5, 16'hBEEF, 8'h00, 3'd0},
    {1'b0, 1'b1, 3'd2, 16'h1234, 8'hA5, 3'd0},
    {1'b1, 1'b0, 3'd6, 16'h07FF, 8'h00, 3'd0},
    {1'b0, 1'b0, 3'd0, 16'h0123, 8'h44, 3'd1},
    {1'b1, 1'b1, 3'd3, 16'h4567, 8'h00, 3'd2},
    {1'b0, 1'b1, 3'd1, 16'h89AB, 8'h77, 3'd3},
    {1'b0, 1'b0, 3'd0, 16'h0210, 8'h99, 3'd3},
    {1'b1, 1'b0, 3'd0, 16'h0555, 8'h00, 3'd3},
    {1'b1, 1'b1, 3'd0, 16'h0000, 8'h00, 3'd0}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_rd = 0, req_ext = 0;
  logic [2:0] req_sel = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic busy, done, err, cmd_valid, cmd_nack;
  logic [7:0] rd_data, cmd_data;
  logic [2:0] err_code;
  logic [1:0] cmd_op;
  logic cmd_done = 0, rx_ack = 0;
  logic [7:0] rx_data = 0;

  int checks = 0, errors = 0;
  int cur_id = 0, last_id = 0, sk = 0;
  logic [2:0] nack_at = 0;
  logic [7:0] model_rd = 0;
  logic [10:0] log_mem [512];
  int log_n = 0;
  logic [10:0] exp_mem [16];
  int exp_n, ek;
  logic ab;
  logic [2:0] exp_code;

  always #(CLK_P/2) clk = ~clk;

  eeprom_cmd_seq u_dut (.*);

  always @(posedge clk) begin
    cmd_done <= 1'b0;
    if (cur_id != last_id) begin
      last_id <= cur_id;
      sk <= 0;
    end else if (cmd_valid && !cmd_done) begin
      if (log_n < 512) log_mem[log_n] <= {cmd_op, cmd_nack, cmd_data};
      log_n <= log_n + 1;
      cmd_done <= 1'b1;
      rx_data <= model_rd;
      rx_ack <= 1'b1;
      if (cmd_op == 2'd2) begin
        sk <= sk + 1;
        if (sk + 1 == int'(nack_at)) rx_ack <= 1'b0;
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic e_push(input logic [1:0] op, input logic nk, input logic [7:0] d);
    if (!ab || op == 2'd1) begin
      exp_mem[exp_n] = {op, nk, d};
      exp_n++;
    end
  endtask

  task automatic e_send(input logic [7:0] b, input logic [2:0] code);
    if (!ab) begin
      e_push(2'd2, 1'b0, b);
      ek++;
      if (ek == int'(nack_at)) begin ab = 1; exp_code = code; end
    end
  endtask

  task automatic build(input logic [31:0] v);
    logic rd, ext;
    logic [2:0] sel;
    logic [15:0] a;
    logic [7:0] ctl;
    rd = v[31]; ext = v[30]; sel = v[29:27]; a = v[26:11];
    exp_n = 0; ek = 0; ab = 0; exp_code = 0;
    ctl = {4'b1010, ext ? sel : a[10:8], 1'b0};
    e_push(2'd0, 1'b0, 8'h00);
    e_send(ctl, 3'd1);
    if (ext) e_send(a[15:8], 3'd2);
    e_send(a[7:0], 3'd3);
    if (!rd) e_send(v[10:3], 3'd4);
    else begin
      e_push(2'd0, 1'b0, 8'h00);
      e_send(ctl | 8'h01, 3'd5);
      e_push(2'd3, 1'b1, 8'h00);
    end
    e_push(2'd1, 1'b0, 8'h00);
  endtask

  task automatic drive_req(input logic [31:0] v);
    req_rd = v[31]; req_ext = v[30]; req_sel = v[29:27];
    req_addr = v[26:11]; req_wdata = v[10:3];
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    if (!done) begin
      errors++;
      $display("FAIL %s done: actual 0 expected 1", req);
    end
  endtask

  task automatic run(input logic [31:0] v, input string tag, input logic stray);
    int base, mism;
    cur_id++;
    nack_at = v[2:0];
    model_rd = v[18:11] ^ 8'h5A;
    @(negedge clk); @(negedge clk);
    base = log_n;
    build(v);
    drive_req(v);
    if (stray) begin
      repeat (3) @(negedge clk);
      req_rd = ~v[31]; req_ext = ~v[30]; req_addr = 16'hFFFF; req_wdata = 8'hEE;
      req_valid = 1;
      @(negedge clk);
      req_valid = 0;
    end
    wait_done(tag);
    // R1 R8: result flags on the done pulse
    check({tag, " R8 err"}, 32'(err), 32'(ab));
    check({tag, " R8 err_code"}, 32'(err_code), 32'(exp_code));
    if (v[31] && !ab) check({tag, " R7 rd_data"}, 32'(rd_data), 32'(model_rd));
    @(negedge clk);
    check({tag, " R1 done one cycle"}, 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    // R1 R2 R3 R4 R5 R6 R7 R8 R10: command sequence
    check({tag, " R1 R10 command count"}, 32'(log_n - base), 32'(exp_n));
    mism = 0;
    for (int i = 0; i < exp_n && i < log_n - base; i++) begin
      logic [10:0] g, e;
      g = log_mem[base + i];
      e = exp_mem[i];
      if (g[10:9] != e[10:9] || g[8] != e[8] || (e[10:9] == 2'd2 && g[7:0] != e[7:0])) begin
        mism++;
        $display("FAIL %s R2 R3 R4 R6 R7 step %0d actual %0h expected %0h", tag, i, g, e);
      end
    end
    checks++;
    if (mism != 0) errors++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 busy", 32'(busy), 0);
    check("R9 cmd_valid", 32'(cmd_valid), 0);
    check("R9 done", 32'(done), 0);
    check("R9 err", 32'(err), 0);
    rst_n = 1;
    @(negedge clk);
    check("R9 idle after release", 32'(busy), 0);

    for (int n = 0; n < NV; n++) begin
      string s;
      s = $sformatf("vec%0d R5", n);
      run(VEC[n], s, 1'b0);
    end

    // R10: stray request during a transaction, both modes
    run({1'b1, 1'b1, 3'd4, 16'hC0DE, 8'h00, 3'd0}, "R10 ext read", 1'b1);
    run({1'b0, 1'b0, 3'd0, 16'h06AA, 8'h3C, 3'd0}, "R10 std write", 1'b1);
    // R8: clean run after abort clears err
    run({1'b0, 1'b1, 3'd7, 16'hFFFF, 8'hFF, 3'd0}, "R8 clear", 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule